// File: doc/BRIEF.md
# I2C Master Bit Engine with Bus Recovery

This block drives an I2C bus as its only master, working at the level of single bus operations. A controller presents one command at a time: bus recovery, START condition, STOP condition, byte write, or byte read with a chosen acknowledge reply. The engine then moves SCL and SDA through a fixed schedule of edges. When the command is complete it raises a one-cycle done pulse. A read returns the received byte, and a write returns the acknowledge level that the addressed device gave.

Both bus lines are open-drain. The engine only ever asserts a pull-low enable for each line, and a high level is produced by letting the line go. The SDA level read back from the pad passes through a two-flop synchroniser before any sample is taken from it. Timing is set by a run-time delay unit, which is a number of system clocks. Every bus phase lasts exactly one delay unit, so the SCL rate can be changed without rebuilding the block.

Bus recovery frees a device that was left in the middle of a transfer. The engine gives nine SCL pulses with SDA let go and then issues a STOP. This lets an upset slave shift out whatever it was sending, so that it sees a clean end of transfer.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset, busy and done are 0 and neither line is pulled low (scl_drive_low = 0, sda_drive_low = 0).
- R2: START (code 2) lasts 4 units. Unit 0 changes nothing, unit 1 lets SDA go, unit 2 lets SCL go, and unit 3 pulls SDA low. The result is exactly one SDA fall while SCL is high, and SCL is left high with SDA low.
- R3: STOP (code 3) lasts 4 units. It pulls SCL low, then pulls SDA low, then lets SCL go, then lets SDA go. The result is exactly one SDA rise while SCL is high, and both lines are left free.
- R4: Write (code 4) sends cmd_wdata most significant bit first. Each bit takes 4 units: SCL low, SDA set to the bit (1 means let go), then SCL high for 2 units. SDA never changes while SCL is high, and no START or STOP condition appears on the bus.
- R5: After the 8 data bits, a write lets SDA go, gives a ninth SCL pulse and samples the synchronised SDA at the end of its second high unit. ack_seen becomes 0 when a device holds SDA low (acknowledge) and 1 when SDA is high (no acknowledge). One final unit then holds SCL low.
- R6: Read (code 5) lets SDA go and gives 8 pulses, each 1 low unit followed by 2 high units. SDA is sampled at the end of the first high unit, and the bits form rx_data most significant bit first. The device's data must reach sda_in at least 2 clocks before the sample edge, so reads use a delay unit of 2 or more.
- R7: After the 8 read bits, the engine drives its reply over 5 units: SCL low, SDA set (pulled low when cmd_nack = 0, let go when cmd_nack = 1), SCL high for 2 units, then SCL low.
- R8: Recovery (code 1) gives 9 SCL pulses, each 2 units low and 2 units high, with SDA let go. A STOP follows, for 40 units in all. The bus is left free with exactly one STOP condition and no START condition.
- R9: An accepted command keeps busy high for N × U clocks. N is 4 for START and STOP, 37 for write, 29 for read and 40 for recovery, and U is the delay unit. done is high for exactly the one cycle in which busy has just fallen.
- R10: A command presented while busy, and any code other than 1 to 5 presented while idle, is ignored. The running command's timing and bus activity do not change, and an idle engine stays idle with its lines unchanged.
- R11: A delay unit of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| unit_cycles | input | UNIT_W | Clocks per bus phase; hold it stable while busy |
| cmd_valid | input | 1 | Command strobe; it is taken only while idle |
| cmd_op | input | 3 | Command code: 1 recovery, 2 START, 3 STOP, 4 write, 5 read |
| cmd_wdata | input | 8 | Byte to send for a write |
| cmd_nack | input | 1 | Reply after a read: 0 acknowledge, 1 no acknowledge |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| rx_data | output | 8 | Last byte read, updated when a read completes |
| ack_seen | output | 1 | Acknowledge level sampled by the last write (0 means acknowledged) |
| scl_drive_low | output | 1 | Pull SCL low when 1, let it go when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, let it go when 0 |
| sda_in | input | 1 | SDA level seen at the pad |

## Verification
The bound checker watches several properties on every cycle. SDA may fall under a high SCL only in a START. SDA may rise under a high SCL only in a STOP, in recovery, or in a START that begins with SDA still held low. The master never moves SDA under a high SCL during a byte. An idle engine with no command keeps its lines still, a presented command never disturbs one that is running, and done lasts one cycle and coincides with busy falling. Other behaviour can be shown only by the bench's scenarios, where a modelled slave answers on the bus. These are the bit order of written and read bytes, the acknowledge level in both directions, the exact number of clocks per command for several delay units, the pulse count and single STOP of recovery, and the treatment of a zero delay unit.

// File: rtl/i2c_eng_pkg.sv
// Shared definitions for the I2C master bit engine.
// Holds the command codes, the per-line actions that a schedule step can
// request, and the length of each command in delay units.
package i2c_eng_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_RECOVER = 3'd1,
        OP_START   = 3'd2,
        OP_STOP    = 3'd3,
        OP_WRITE   = 3'd4,
        OP_READ    = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        LA_KEEP = 2'd0,
        LA_LOW  = 2'd1,
        LA_REL  = 2'd2
    } line_act_e;

    localparam int STEP_W        = 6;
    localparam int BYTE_BITS     = 8;
    localparam int W_UNITS_BIT   = 4;
    localparam int R_UNITS_BIT   = 3;
    localparam int RECOV_PULSES  = 9;
    localparam int W_BODY        = (BYTE_BITS + 1) * W_UNITS_BIT;   // 36
    localparam int R_BODY        = BYTE_BITS * R_UNITS_BIT;         // 24
    localparam int RECOV_BODY    = RECOV_PULSES * W_UNITS_BIT;      // 36
    localparam int N_START       = 4;
    localparam int N_STOP        = 4;
    localparam int N_WRITE       = W_BODY + 1;                      // 37
    localparam int N_READ        = R_BODY + 5;                      // 29
    localparam int N_RECOVER     = RECOV_BODY + N_STOP;             // 40

    // True for the command codes the engine executes.
    function automatic logic op_known(input logic [2:0] code);
        return (code >= 3'(OP_RECOVER)) && (code <= 3'(OP_READ));
    endfunction

endpackage

// File: rtl/i2c_unit_timer.sv
// Delay-unit timer.
// Produces a one-cycle tick every unit_cycles clocks, and restart realigns
// the count. A programmed value of zero is treated as one. Assumes
// unit_cycles is held stable while a command is running.
module i2c_unit_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] unit_cycles,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = (unit_cycles == '0) ? CNT_W'(1) : unit_cycles;
    assign tick  = (cnt == limit - CNT_W'(1));

    // Count clocks inside the current unit and wrap at the unit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (restart || tick) cnt <= '0;
        else                     cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/i2c_in_sync.sv
// Multi-flop synchroniser for an asynchronous pad input.
// Resets to 1, the free level of an open-drain line. Assumes STAGES >= 2.
module i2c_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr;

    // Shift the pad level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], din};
    end

    assign dout = sr[STAGES-1];
endmodule

// File: rtl/i2c_step_decode.sv
// Schedule decoder: for a command and a unit index it gives the action
// applied to each line at the start of that unit, whether a read bit or an
// acknowledge is sampled at its end, and whether it is the last unit.
// Purely combinational. Assumes step stays below the command's length.
module i2c_step_decode
    import i2c_eng_pkg::*;
(
    input  logic [2:0]        op,
    input  logic [STEP_W-1:0] step,
    input  logic [7:0]        wbyte,
    input  logic              nack,
    output line_act_e         scl_act,
    output line_act_e         sda_act,
    output logic              smp_rx,
    output logic              smp_ack,
    output logic              last
);
    logic [3:0]        wslot;
    logic [1:0]        wph;
    logic [3:0]        rslot;
    logic [1:0]        rph;
    logic [2:0]        widx;
    logic [STEP_W-1:0] rtail;

    assign wslot = 4'(step >> 2);
    assign wph   = step[1:0];
    assign rslot = 4'(step / STEP_W'(R_UNITS_BIT));
    assign rph   = 2'(step % STEP_W'(R_UNITS_BIT));
    assign widx  = 3'(4'd7 - wslot);
    assign rtail = step - STEP_W'(R_BODY);

    // Map (command, unit) to line actions and sample strobes.
    always_comb begin
        scl_act = LA_KEEP;
        sda_act = LA_KEEP;
        smp_rx  = 1'b0;
        smp_ack = 1'b0;
        last    = 1'b0;
        case (op)
            3'(OP_START): begin
                case (step[1:0])
                    2'd1:    sda_act = LA_REL;
                    2'd2:    scl_act = LA_REL;
                    2'd3:    begin sda_act = LA_LOW; last = 1'b1; end
                    default: ;
                endcase
            end
            3'(OP_STOP), 3'(OP_RECOVER): begin
                if (op == 3'(OP_RECOVER) && step < STEP_W'(RECOV_BODY)) begin
                    if (wph == 2'd0) begin
                        scl_act = LA_LOW;
                        sda_act = LA_REL;
                    end else if (wph == 2'd2) begin
                        scl_act = LA_REL;
                    end
                end else begin
                    case (step[1:0])
                        2'd0:    scl_act = LA_LOW;
                        2'd1:    sda_act = LA_LOW;
                        2'd2:    scl_act = LA_REL;
                        default: begin sda_act = LA_REL; last = 1'b1; end
                    endcase
                end
            end
            3'(OP_WRITE): begin
                if (step < STEP_W'(W_BODY)) begin
                    case (wph)
                        2'd0: scl_act = LA_LOW;
                        2'd1: sda_act = (wslot < 4'd8 && !wbyte[widx]) ? LA_LOW : LA_REL;
                        2'd2: scl_act = LA_REL;
                        default: smp_ack = (wslot == 4'd8);
                    endcase
                end else begin
                    scl_act = LA_LOW;
                    last    = 1'b1;
                end
            end
            3'(OP_READ): begin
                if (step < STEP_W'(R_BODY)) begin
                    if (rph == 2'd0) begin
                        scl_act = LA_LOW;
                        sda_act = LA_REL;
                    end else if (rph == 2'd1) begin
                        scl_act = LA_REL;
                        smp_rx  = (rslot < 4'd8);
                    end
                end else begin
                    case (rtail)
                        STEP_W'(0): scl_act = LA_LOW;
                        STEP_W'(1): sda_act = nack ? LA_REL : LA_LOW;
                        STEP_W'(2): scl_act = LA_REL;
                        STEP_W'(4): begin scl_act = LA_LOW; last = 1'b1; end
                        default:    ;
                    endcase
                end
            end
            default: last = 1'b1;
        endcase
    end
endmodule

// File: rtl/i2c_bit_engine.sv
// I2C master bit engine (top).
// Accepts one command while idle, steps through its unit schedule with the
// unit timer, drives the open-drain pull-low enables, samples the
// synchronised SDA and pulses done at the end. Assumes it is the only
// master and that no device stretches the clock.
module i2c_bit_engine
    import i2c_eng_pkg::*;
#(
    parameter int UNIT_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [UNIT_W-1:0] unit_cycles,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [7:0]        cmd_wdata,
    input  logic              cmd_nack,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rx_data,
    output logic              ack_seen,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic              sda_in
);
    logic [2:0]        op_q;
    logic [7:0]        wdata_q;
    logic              nack_q;
    logic [STEP_W-1:0] step_q;
    logic [7:0]        rx_shift;
    logic              sda_s;
    logic              tick;
    logic              accept;
    logic              advance;

    logic [2:0]        nx_op;
    logic [STEP_W-1:0] nx_step;
    logic [7:0]        nx_wbyte;
    logic              nx_nack;
    line_act_e         nx_scl, nx_sda, cu_scl, cu_sda;
    logic              nx_smp_rx, nx_smp_ack, nx_last;
    logic              cu_smp_rx, cu_smp_ack, cu_last;

    assign accept  = cmd_valid && !busy && op_known(cmd_op);
    assign advance = busy && tick && !cu_last;

    assign nx_op    = accept ? cmd_op    : op_q;
    assign nx_step  = accept ? '0        : step_q + STEP_W'(1);
    assign nx_wbyte = accept ? cmd_wdata : wdata_q;
    assign nx_nack  = accept ? cmd_nack  : nack_q;

    i2c_unit_timer #(.CNT_W(UNIT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(accept),
        .unit_cycles(unit_cycles), .tick(tick)
    );

    i2c_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(sda_in), .dout(sda_s)
    );

    // Decoder for the unit about to begin.
    i2c_step_decode u_dec_next (
        .op(nx_op), .step(nx_step), .wbyte(nx_wbyte), .nack(nx_nack),
        .scl_act(nx_scl), .sda_act(nx_sda),
        .smp_rx(nx_smp_rx), .smp_ack(nx_smp_ack), .last(nx_last)
    );

    // Decoder for the unit now running.
    i2c_step_decode u_dec_cur (
        .op(op_q), .step(step_q), .wbyte(wdata_q), .nack(nack_q),
        .scl_act(cu_scl), .sda_act(cu_sda),
        .smp_rx(cu_smp_rx), .smp_ack(cu_smp_ack), .last(cu_last)
    );

    // Apply the line actions at the start of each unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_drive_low <= 1'b0;
            sda_drive_low <= 1'b0;
        end else if (accept || advance) begin
            if (nx_scl == LA_LOW)      scl_drive_low <= 1'b1;
            else if (nx_scl == LA_REL) scl_drive_low <= 1'b0;
            if (nx_sda == LA_LOW)      sda_drive_low <= 1'b1;
            else if (nx_sda == LA_REL) sda_drive_low <= 1'b0;
        end
    end

    // Command capture, unit stepping, completion and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            op_q    <= 3'(OP_NONE);
            wdata_q <= '0;
            nack_q  <= 1'b0;
            step_q  <= '0;
            rx_data <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                op_q    <= cmd_op;
                wdata_q <= cmd_wdata;
                nack_q  <= cmd_nack;
                step_q  <= '0;
            end else if (busy && tick) begin
                if (cu_last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    if (op_q == 3'(OP_READ)) rx_data <= rx_shift;
                end else begin
                    step_q <= nx_step;
                end
            end
        end
    end

    // Sample read bits and the device acknowledge at the end of a unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_shift <= '0;
            ack_seen <= 1'b0;
        end else if (busy && tick) begin
            if (cu_smp_rx)  rx_shift <= {rx_shift[6:0], sda_s};
            if (cu_smp_ack) ack_seen <= sda_s;
        end
    end
endmodule

// File: rtl/i2c_bit_engine_checker.sv
// Protocol checker for the I2C master bit engine, bound to every instance.
// Observes ports and the latched command code only.
module i2c_bit_engine_checker
    import i2c_eng_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       busy,
    input logic       done,
    input logic       scl_drive_low,
    input logic       sda_drive_low,
    input logic [2:0] op_q
);
    // R1: reset leaves the engine idle with both lines free.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !scl_drive_low && !sda_drive_low));

    // R2: SDA may fall under a high SCL only in a START.
    p_start_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_drive_low && $past(!scl_drive_low) && $rose(sda_drive_low))
        |-> (op_q == 3'(OP_START)));

    // R3: SDA may rise under a high SCL only in STOP, recovery, or a START
    // that begins with SDA still held low.
    p_stop_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_drive_low && $past(!scl_drive_low) && $fell(sda_drive_low))
        |-> (op_q == 3'(OP_STOP) || op_q == 3'(OP_RECOVER) || op_q == 3'(OP_START)));

    // R4: during byte transfers the master holds SDA while SCL is high.
    p_byte_sda_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (op_q == 3'(OP_WRITE) || op_q == 3'(OP_READ))
         && !scl_drive_low && $past(!scl_drive_low))
        |-> $stable(sda_drive_low));

    // R9: done lasts one cycle.
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done accompanies the end of busy.
    p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10: a command presented while busy leaves the running one alone.
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable(op_q));

    // R10: an idle engine with no command keeps its lines still.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid) |=> (!busy && $stable(scl_drive_low) && $stable(sda_drive_low)));
endmodule

bind i2c_bit_engine i2c_bit_engine_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .op_q(op_q)
);

// File: tb/i2c_bit_engine_test.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every byte value for write and read at
// several delay units, with a modelled slave on SDA and a bus monitor.
module i2c_bit_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] unit_cycles = 16'd1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  cmd_wdata = 8'd0;
    logic        cmd_nack = 1'b0;
    logic        busy, done, ack_seen, scl_drive_low, sda_drive_low, sda_in;
    logic [7:0]  rx_data;
    logic        slave_low = 1'b0;

    int checks = 0;
    int errors = 0;

    // Bus monitor state.
    int          rises = 0, starts = 0, stops = 0, rise_base = 0;
    logic [15:0] cap = '0;
    logic        p_scl = 1'b1, p_sda = 1'b1, s_c, d_c;
    int          slave_mode = 0;   // 0 quiet, 1 send byte, 2 acknowledge
    logic [7:0]  slave_byte = '0;
    logic        slave_ack = 1'b0;

    // Results of the last command.
    int          bcyc, d_rises, d_starts, d_stops;
    logic        done_end, done_after;

    localparam logic [2:0] C_REC = 3'd1, C_STA = 3'd2, C_STO = 3'd3,
                           C_WR = 3'd4, C_RD = 3'd5;

    always #2.5 clk = ~clk;

    assign sda_in = ~sda_drive_low & ~slave_low;

    i2c_bit_engine uut (
        .clk(clk), .rst_n(rst_n), .unit_cycles(unit_cycles),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
        .cmd_nack(cmd_nack), .busy(busy), .done(done), .rx_data(rx_data),
        .ack_seen(ack_seen), .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low), .sda_in(sda_in)
    );

    function automatic logic slave_drive(input int idx);
        if (slave_mode == 1) return (idx < 8) ? ~slave_byte[7 - idx] : 1'b0;
        if (slave_mode == 2) return (idx == 8) ? slave_ack : 1'b0;
        return 1'b0;
    endfunction

    // Watch the bus: count SCL rises and START/STOP conditions, capture SDA
    // at each rise, and let the slave move SDA only while SCL is low.
    always @(negedge clk) begin
        s_c = ~scl_drive_low;
        d_c = sda_in;
        if (rst_n) begin
            if (s_c && !p_scl) begin
                rises = rises + 1;
                cap = {cap[14:0], d_c};
            end
            if (s_c && p_scl && d_c != p_sda) begin
                if (!d_c) starts = starts + 1;
                else      stops = stops + 1;
            end
            if (!s_c) slave_low <= slave_drive(rises - rise_base);
        end
        p_scl = s_c;
        p_sda = d_c;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue one command, optionally present a second while busy, and wait.
    task automatic run_cmd(input logic [2:0] op, input logic [7:0] wd,
                           input logic nk, input logic [2:0] poke_op);
        int b_r, b_s, b_p;
        @(negedge clk);
        b_r = rises; b_s = starts; b_p = stops;
        rise_base = rises;
        cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_nack = nk;
        @(negedge clk);
        cmd_valid = 1'b0;
        bcyc = 0;
        while (busy && bcyc < 100000) begin
            bcyc++;
            if (poke_op != 3'd0 && bcyc == 5) begin
                cmd_valid = 1'b1; cmd_op = poke_op; cmd_wdata = ~wd; cmd_nack = ~nk;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        if (bcyc >= 100000) check(1'b0, "R9 command hung", bcyc, 0);
        done_end = done;
        @(negedge clk);
        done_after = done;
        d_rises = rises - b_r;
        d_starts = starts - b_s;
        d_stops = stops - b_p;
    endtask

    task automatic check_timing(input string tag, input int n_units, input int u);
        int ue;
        ue = (u == 0) ? 1 : u;
        check(bcyc == n_units * ue, {tag, " busy clocks"}, bcyc, n_units * ue);
        check(done_end == 1'b1, "R9 done at end", done_end, 1);
        check(done_after == 1'b0, "R9 done single cycle", done_after, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(scl_drive_low == 1'b0, "R1 scl", scl_drive_low, 0);
        check(sda_drive_low == 1'b0, "R1 sda", sda_drive_low, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8, R2, R3 at two delay units.
        for (int u = 1; u <= 2; u++) begin
            unit_cycles = 16'(u);
            slave_mode = 0;
            run_cmd(C_REC, 8'h00, 1'b0, 3'd0);
            check_timing("R8", 40, u);
            check(d_rises == 10, "R8 scl pulses", d_rises, 10);
            check(d_stops == 1 && d_starts == 0, "R8 single stop", d_stops, 1);
            check(!scl_drive_low && !sda_drive_low, "R8 bus free", {scl_drive_low, sda_drive_low}, 0);
            run_cmd(C_STA, 8'h00, 1'b0, 3'd0);
            check_timing("R2", 4, u);
            check(d_starts == 1 && d_stops == 0, "R2 start condition", d_starts, 1);
            check(!scl_drive_low && sda_drive_low, "R2 end levels", {scl_drive_low, sda_drive_low}, 1);
            run_cmd(C_STO, 8'h00, 1'b0, 3'd0);
            check_timing("R3", 4, u);
            check(d_stops == 1 && d_starts == 0, "R3 stop condition", d_stops, 1);
            check(d_rises == 1, "R3 one scl rise", d_rises, 1);
            check(!scl_drive_low && !sda_drive_low, "R3 bus free", {scl_drive_low, sda_drive_low}, 0);
        end

        // R4, R5: every byte written, acknowledge alternating.
        for (int u = 1; u <= 2; u++) begin
            unit_cycles = 16'(u);
            slave_mode = 0;
            run_cmd(C_STA, 8'h00, 1'b0, 3'd0);
            for (int b = 0; b < 256; b++) begin
                slave_mode = 2;
                slave_ack = b[0];
                run_cmd(C_WR, 8'(b), 1'b0, 3'd0);
                check_timing("R9 write", 37, u);
                check(cap[8:1] == 8'(b), "R4 bits on bus", cap[8:1], b);
                check(d_rises == 9 && d_starts == 0 && d_stops == 0, "R4 clean byte", d_rises, 9);
                check(ack_seen == ~b[0], "R5 ack_seen", ack_seen, ~b[0]);
                check(cap[0] == ~b[0], "R5 ack on bus", cap[0], ~b[0]);
                check(scl_drive_low == 1'b1, "R5 scl left low", scl_drive_low, 1);
            end
            slave_mode = 0;
            run_cmd(C_STO, 8'h00, 1'b0, 3'd0);
        end

        // R6, R7: every byte read, reply varied.
        for (int u = 2; u <= 3; u++) begin
            unit_cycles = 16'(u);
            for (int b = 0; b < 256; b++) begin
                slave_mode = 1;
                slave_byte = 8'(b);
                run_cmd(C_RD, 8'h00, b[0] ^ b[7], 3'd0);
                check_timing("R9 read", 29, u);
                check(rx_data == 8'(b), "R6 rx_data", rx_data, b);
                check(cap[0] == (b[0] ^ b[7]), "R7 reply level", cap[0], b[0] ^ b[7]);
                check(d_rises == 9 && d_starts == 0 && d_stops == 0, "R7 clean byte", d_rises, 9);
            end
        end

        // R10: command while busy is ignored.
        unit_cycles = 16'd2;
        slave_mode = 2;
        slave_ack = 1'b1;
        run_cmd(C_WR, 8'hA5, 1'b0, C_STO);
        check_timing("R10 busy poke", 37, 2);
        check(cap[8:1] == 8'hA5, "R10 byte intact", cap[8:1], 8'hA5);
        check(d_stops == 0, "R10 no stop", d_stops, 0);
        slave_mode = 0;
        // R10: unknown codes while idle are ignored.
        for (int c = 0; c < 8; c += 6) begin
            logic sl, sd;
            @(negedge clk);
            sl = scl_drive_low; sd = sda_drive_low;
            cmd_valid = 1'b1; cmd_op = (c == 0) ? 3'd0 : 3'd7;
            @(negedge clk);
            cmd_valid = 1'b0;
            @(negedge clk);
            check(busy == 1'b0, "R10 unknown code idle", busy, 0);
            check(scl_drive_low == sl && sda_drive_low == sd, "R10 lines unchanged",
                  {scl_drive_low, sda_drive_low}, {sl, sd});
        end

        // R11: zero delay unit acts as one.
        unit_cycles = 16'd0;
        run_cmd(C_STO, 8'h00, 1'b0, 3'd0);
        check_timing("R11", 4, 0);
        run_cmd(C_STA, 8'h00, 1'b0, 3'd0);
        check_timing("R11", 4, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule